// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors held in system memory and turns each frame that the host has handed over into a byte stream. It reaches memory through a byte-wide master port. Each descriptor holds the address of a frame buffer, a status byte and a negated byte count. The engine uses only descriptors whose status byte marks them as owned by the controller and as a complete frame. For each one it streams the buffer out with start and end markers, hands the descriptor back to the host by rewriting its status byte, and pulses a transmit-done event.

A scan starts when the host writes any register (the `kick` pulse) and the engine is not held in stop. It starts at the ring pointer and goes round the ring in increasing order, modulo the ring size. It stops one entry before a full lap. The ring pointer moves forward by one for every frame sent.

The controller is a single state machine with these states. `S_IDLE` waits for a start. `S_FREQ` issues one descriptor byte read and `S_FCAP` captures that byte; the machine alternates between the two until six bytes are in. `S_EVAL` tests the status byte. `S_DATA` streams buffer reads. `S_DRAIN` presents the last byte and writes the status back. `S_NEXT` moves to the next entry.

The transitions are:
- IDLE→FREQ on a start.
- FCAP→FREQ while bytes remain, and FCAP→EVAL after the sixth byte.
- EVAL→DATA for a ready entry, and EVAL→NEXT otherwise.
- DATA→DRAIN on the final byte.
- DRAIN→NEXT.
- NEXT→FREQ to continue the scan, and NEXT→IDLE at the end of the lap or when stop is set.

Top module: `txring_engine`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr`, `tx_valid` and `tint` are low, and the first scan begins at ring entry 0.
- R2: An entry is transmitted only when its status byte, at offset 2 of the descriptor, equals exactly 0x83 (owned, first segment, last segment). Any other value is skipped and left unchanged.
- R3: Entry i sits at (`ring_base` with its low three bits cleared) + 8·i. The buffer address is {byte 3, byte 0, byte 1}. The length field is byte 4 (upper half) followed by byte 5 (lower half).
- R4: The byte count is the 16-bit two's-complement negation of the length field. A count of zero, or one above `MAX_LEN`, is replaced by `MAX_LEN`.
- R5: A frame's bytes appear on `tx_data` in buffer order on consecutive `tx_valid` cycles. `tx_sop` is set on the first byte and `tx_eop` on the last.
- R6: After a frame's last byte is read, the engine writes 0x03 to that entry's status byte. `tint` pulses high for one cycle for each frame sent.
- R7: A scan examines entries ptr, ptr+1, … modulo the ring size, 2^`RING_LOG`−1 entries in all, so entry ptr−1 is not examined. The pointer advances by one per frame sent.
- R8: While `stop` is high, a kick is ignored and not remembered. A `stop` raised during a scan ends the scan at the next entry boundary, and a frame already in progress completes.
- R9: A kick that arrives while a scan is in progress causes exactly one further scan after the current one ends.
- R10: Read data is taken from `mem_rdata` one cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_base | input | ADDR_W | Byte address of descriptor ring (low 3 bits ignored) |
| kick | input | 1 | One-cycle scan request |
| stop | input | 1 | Hold the engine stopped |
| mem_rd | output | 1 | Byte read request |
| mem_wr | output | 1 | Byte write request |
| mem_addr | output | ADDR_W | Byte address of request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of frame |
| tx_eop | output | 1 | Last byte of frame |
| tint | output | 1 | One-cycle pulse per frame sent |

## Verification
The bench builds the engine with `RING_LOG` = 4, `MAX_LEN` = 64 and `ADDR_W` = 24. The short maximum makes the count clamp for zero and oversized lengths cheap to hit in every random round. The 16-entry ring lets the pointer wrap several times within a few dozen scans, so scans that start mid-ring and the entry skipped just before the pointer are both exercised. A double-kick scan and a stop raised during the first descriptor fetch cover the restart and early-exit paths.

// File: rtl/txr_pkg.sv
package txr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FREQ,
        S_FCAP,
        S_EVAL,
        S_DATA,
        S_DRAIN,
        S_NEXT
    } txr_state_e;

    localparam logic [7:0] ST_READY    = 8'h83;
    localparam logic [7:0] ST_RETURNED = 8'h03;
    localparam int         ENTRY_SHIFT = 3;
    localparam int         OFF_STATUS  = 2;
    localparam logic [2:0] FETCH_LAST  = 3'd5;
endpackage

// File: rtl/txr_len_decode.sv
module txr_len_decode #(
    parameter int MAX_LEN = 1544,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [7:0]       len_hi,
    input  logic [7:0]       len_lo,
    output logic [CNT_W-1:0] byte_cnt
);
    logic [15:0] raw;
    logic [15:0] mag;
    logic        out_of_range;

    always_comb begin
        raw          = {len_hi, len_lo};
        mag          = ~raw + 16'd1;
        out_of_range = (mag == 16'd0) || (mag > 16'(MAX_LEN));
        byte_cnt     = out_of_range ? CNT_W'(MAX_LEN) : mag[CNT_W-1:0];
    end
endmodule

// File: rtl/txr_ring_idx.sv
module txr_ring_idx #(
    parameter int RING_LOG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic                adv,
    output logic [RING_LOG-1:0] cur_idx,
    output logic                last_entry
);
    localparam int RING = 1 << RING_LOG;
    localparam logic [RING_LOG-1:0] LAST_SEEN = RING_LOG'(RING - 2);

    logic [RING_LOG-1:0] ptr_q;
    logic [RING_LOG-1:0] idx_q;
    logic [RING_LOG-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            idx_q  <= '0;
            seen_q <= '0;
        end else begin
            if (adv) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (load) begin
                idx_q  <= ptr_q;
                seen_q <= '0;
            end else if (step) begin
                idx_q  <= idx_q + 1'b1;
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    assign cur_idx    = idx_q;
    assign last_entry = (seen_q == LAST_SEEN);
endmodule

// File: rtl/txr_stream_out.sv
module txr_stream_out (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic first,
    input  logic final_byte,
    output logic vld,
    output logic sop,
    output logic eop
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= 1'b0;
            sop <= 1'b0;
            eop <= 1'b0;
        end else begin
            vld <= issue;
            sop <= issue && first;
            eop <= issue && final_byte;
        end
    end
endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
    parameter int RING_LOG = 4,
    parameter int MAX_LEN  = 1544,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              kick,
    input  logic              stop,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tint
);
    import txr_pkg::*;

    localparam int CNT_W = $clog2(MAX_LEN + 1);

    txr_state_e state_q, state_d;

    logic [7:0]          desc_q [0:7];
    logic [2:0]          boff_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    bidx_q;
    logic                kick_pend_q;
    logic                tint_q;

    logic [RING_LOG-1:0] cur_idx;
    logic                scan_done;
    logic [CNT_W-1:0]    dec_cnt;
    logic                start_scan;
    logic                first_byte;
    logic                final_byte;
    logic                issue;
    logic [ADDR_W-1:0]   base_al;
    logic [ADDR_W-1:0]   desc_base;
    logic [ADDR_W-1:0]   buf_addr;

    // descriptor and buffer addressing
    assign base_al    = ring_base & ~ADDR_W'(7);
    assign desc_base  = base_al + ADDR_W'({cur_idx, 3'b000});
    assign buf_addr   = ADDR_W'({desc_q[3], desc_q[0], desc_q[1]});
    assign start_scan = !stop && (kick || kick_pend_q);
    assign first_byte = (bidx_q == '0);
    assign final_byte = (bidx_q == cnt_q - CNT_W'(1));

    txr_len_decode #(
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_len (
        .len_hi   (desc_q[4]),
        .len_lo   (desc_q[5]),
        .byte_cnt (dec_cnt)
    );

    txr_ring_idx #(
        .RING_LOG (RING_LOG)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state_q == S_IDLE && start_scan),
        .step       (state_q == S_NEXT),
        .adv        (state_q == S_DRAIN),
        .cur_idx    (cur_idx),
        .last_entry (scan_done)
    );

    txr_stream_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .first      (first_byte),
        .final_byte (final_byte),
        .vld        (tx_valid),
        .sop        (tx_sop),
        .eop        (tx_eop)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_scan) state_d = S_FREQ;
            S_FREQ:  state_d = S_FCAP;
            S_FCAP:  state_d = (boff_q == FETCH_LAST) ? S_EVAL : S_FREQ;
            S_EVAL:  state_d = (desc_q[OFF_STATUS] == ST_READY) ? S_DATA : S_NEXT;
            S_DATA:  if (final_byte) state_d = S_DRAIN;
            S_DRAIN: state_d = S_NEXT;
            S_NEXT:  state_d = (scan_done || stop) ? S_IDLE : S_FREQ;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = 8'h00;
        issue     = 1'b0;
        unique case (state_q)
            S_FREQ: begin
                mem_rd   = 1'b1;
                mem_addr = desc_base + ADDR_W'(boff_q);
            end
            S_DATA: begin
                mem_rd   = 1'b1;
                mem_addr = buf_addr + ADDR_W'(bidx_q);
                issue    = 1'b1;
            end
            S_DRAIN: begin
                mem_wr    = 1'b1;
                mem_addr  = desc_base + ADDR_W'(OFF_STATUS);
                mem_wdata = ST_RETURNED;
            end
            default: ;
        endcase
    end

    assign tx_data = tx_valid ? mem_rdata : 8'h00;
    assign tint    = tint_q;

    // control datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boff_q      <= '0;
            cnt_q       <= '0;
            bidx_q      <= '0;
            kick_pend_q <= 1'b0;
            tint_q      <= 1'b0;
        end else begin
            tint_q <= (state_q == S_DRAIN);

            if (stop || state_q == S_IDLE) begin
                kick_pend_q <= 1'b0;
            end else if (kick) begin
                kick_pend_q <= 1'b1;
            end

            unique case (state_q)
                S_IDLE, S_NEXT: boff_q <= '0;
                S_FCAP:         boff_q <= boff_q + 3'd1;
                S_EVAL: begin
                    cnt_q  <= dec_cnt;
                    bidx_q <= '0;
                end
                S_DATA:         bidx_q <= bidx_q + CNT_W'(1);
                default: ;
            endcase
        end
    end

    // descriptor byte capture
    always_ff @(posedge clk) begin
        if (state_q == S_FCAP) begin
            desc_q[boff_q] <= mem_rdata;
        end
    end
endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic [7:0] mem_wdata,
    input logic       tx_valid,
    input logic       tx_sop,
    input logic       tx_eop,
    input logic       tint
);
    p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_data_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(mem_rd));

    p_wb_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == 8'h03));

    p_tint_follows_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> tint);

    p_tint_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tint |=> !tint);

    p_eop_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_eop) |=> !tx_valid);

    p_markers_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sop || tx_eop) |-> tx_valid);
endmodule

bind txring_engine txring_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .tx_valid  (tx_valid),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop),
    .tint      (tint)
);

// File: tb/txring_engine_test.sv
`timescale 1ns/1ps
module txring_engine_test;
    localparam int RL   = 4;
    localparam int RING = 1 << RL;
    localparam int MAXL = 64;
    localparam int AW   = 24;
    localparam int BUF0 = 'h400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_base = 24'h000100;
    logic          kick = 1'b0;
    logic          stop = 1'b0;
    logic          mem_rd, mem_wr, tx_valid, tx_sop, tx_eop, tint;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, tx_data;
    logic [7:0]    mem_rdata;

    always #2.5 clk = ~clk;

    txring_engine #(.RING_LOG(RL), .MAX_LEN(MAXL), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .kick(kick), .stop(stop),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .tint(tint)
    );

    // memory model: host setup port plus engine port
    logic [7:0]  mem [0:4095];
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [7:0]  host_data = '0;

    always @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_data;
        else if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    end

    // stream monitor
    logic [9:0] got_q [$];
    int         tint_cnt = 0;
    always @(negedge clk) begin
        if (tx_valid) got_q.push_back({tx_sop, tx_eop, tx_data});
        if (tint) tint_cnt++;
    end

    int         checks = 0, fails = 0;
    int         got_rd = 0, tint_seen = 0, exp_frames = 0, mptr = 0;
    bit         done = 1'b0;
    logic [7:0]  m_st  [RING];
    logic [15:0] m_len [RING];
    logic [9:0]  exp_q [$];

    function automatic int cnt_of(logic [15:0] len);
        logic [15:0] m;
        m = ~len + 16'd1;
        if (m == 16'd0 || m > 16'(MAXL)) return MAXL;
        return int'(m);
    endfunction

    function automatic logic [15:0] len_of(int n);
        return 16'(0 - n);
    endfunction

    function automatic int desc_at(int i);
        return int'({ring_base[11:3], 3'b000}) + 8 * i;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hwrite(int a, logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a[11:0]; host_data = d;
    endtask

    task automatic hdone();
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // R3 layout: bytes 0,1 buffer address, 2 status, 3 high address, 4,5 length
    task automatic set_desc(int i, logic [7:0] st, logic [15:0] len);
        int a, b;
        a = desc_at(i);
        b = BUF0 + i * MAXL;
        hwrite(a + 0, 8'(b >> 8));
        hwrite(a + 1, 8'(b));
        hwrite(a + 2, st);
        hwrite(a + 3, 8'h00);
        hwrite(a + 4, len[15:8]);
        hwrite(a + 5, len[7:0]);
        m_st[i]  = st;
        m_len[i] = len;
    endtask

    // R7: scan model from the pointer, lim entries
    task automatic model_scan(int lim);
        int start, i, n, b;
        start = mptr;
        for (int k = 0; k < lim; k++) begin
            i = (start + k) % RING;
            if (m_st[i] == 8'h83) begin
                n = cnt_of(m_len[i]);
                b = BUF0 + i * MAXL;
                for (int j = 0; j < n; j++)
                    exp_q.push_back({(j == 0), (j == n - 1), mem[b + j]});
                m_st[i] = 8'h03;
                mptr = (mptr + 1) % RING;
                exp_frames++;
            end
        end
    endtask

    task automatic kick_pulse();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic wait_quiet();
        int q, t;
        q = 0; t = 0;
        while (q < 40 && t < 20000) begin
            @(negedge clk);
            if (mem_rd || mem_wr || tx_valid) q = 0; else q++;
            t++;
        end
        if (t >= 20000) check(1'b0, "R5", "engine never idle", t, 0);
    endtask

    task automatic compare(string tag);
        int got_n, lim;
        got_n = got_q.size() - got_rd;
        check(got_n == exp_q.size(), tag, "stream length", got_n, exp_q.size());
        lim = (got_n < exp_q.size()) ? got_n : exp_q.size();
        for (int k = 0; k < lim; k++)
            check(got_q[got_rd + k] == exp_q[k], "R5", "stream byte {sop,eop,data}",
                  int'(got_q[got_rd + k]), int'(exp_q[k]));
        got_rd = got_q.size();
        exp_q.delete();
        check(tint_cnt - tint_seen == exp_frames, "R6", "tint pulses",
              tint_cnt - tint_seen, exp_frames);
        tint_seen  = tint_cnt;
        exp_frames = 0;
        for (int i = 0; i < RING; i++)
            check(mem[desc_at(i) + 2] == m_st[i], "R6", "status byte",
                  int'(mem[desc_at(i) + 2]), int'(m_st[i]));
    endtask

    function automatic logic [7:0] pick_status();
        int r;
        r = int'($urandom % 8);
        if (r < 4)  return 8'h83;
        if (r == 4) return 8'h03;
        if (r == 5) return 8'h80;
        if (r == 6) return 8'h82;
        return 8'h83 ^ 8'(1 << ($urandom % 7));
    endfunction

    function automatic logic [15:0] pick_len();
        int r;
        r = int'($urandom % 10);
        if (r == 0) return 16'h0000;
        if (r == 1) return len_of(MAXL + 1 + int'($urandom % 200));
        return len_of(1 + int'($urandom % MAXL));
    endfunction

    task automatic rand_round(string tag);
        for (int i = 0; i < RING; i++) set_desc(i, pick_status(), pick_len());
        hdone();
        model_scan(RING - 1);
        kick_pulse();
        wait_quiet();
        compare(tag);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int act;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!mem_rd && !mem_wr, "R1", "memory port idle after reset", {mem_rd, mem_wr}, 0);
        check(!tx_valid && !tint, "R1", "stream and event idle after reset", {tx_valid, tint}, 0);

        for (int a = BUF0; a < BUF0 + RING * MAXL; a++) hwrite(a, 8'($urandom));
        hdone();

        // R1, R7: all ready from pointer 0, entry 15 left untouched
        for (int i = 0; i < RING; i++) set_desc(i, 8'h83, len_of(1 + i));
        hdone();
        model_scan(RING - 1);
        kick_pulse();
        wait_quiet();
        compare("R1");

        // R3: ring base with low bits set behaves as aligned base
        ring_base = 24'h000105;
        rand_round("R3");

        // R4: zero, oversized, maximum and minimum counts
        for (int i = 0; i < RING; i++) set_desc(i, 8'h03, len_of(4));
        set_desc((mptr + 0) % RING, 8'h83, 16'h0000);
        set_desc((mptr + 1) % RING, 8'h83, len_of(MAXL + 5));
        set_desc((mptr + 2) % RING, 8'h83, len_of(MAXL));
        set_desc((mptr + 3) % RING, 8'h83, len_of(1));
        hdone();
        model_scan(RING - 1);
        kick_pulse();
        wait_quiet();
        compare("R4");

        // R2, R10: random rounds
        for (int r = 0; r < 10; r++) rand_round((r == 0) ? "R10" : "R2");

        // R8: kick ignored under stop and not remembered
        for (int i = 0; i < RING; i++) set_desc(i, 8'h83, len_of(8));
        hdone();
        stop = 1'b1;
        kick_pulse();
        act = 0;
        repeat (60) begin @(negedge clk); if (mem_rd || mem_wr) act++; end
        stop = 1'b0;
        repeat (60) begin @(negedge clk); if (mem_rd || mem_wr) act++; end
        check(act == 0, "R8", "memory activity after kick under stop", act, 0);
        compare("R8");

        // R8: stop during first fetch ends scan after first entry
        model_scan(1);
        kick_pulse();
        repeat (3) @(negedge clk);
        stop = 1'b1;
        wait_quiet();
        stop = 1'b0;
        compare("R8");

        // R9: second kick while busy gives one more scan
        for (int i = 0; i < RING; i++) set_desc(i, 8'h83, pick_len());
        hdone();
        model_scan(RING - 1);
        model_scan(RING - 1);
        kick_pulse();
        repeat (5) @(negedge clk);
        kick_pulse();
        wait_quiet();
        compare("R9");

        // R7: more random rounds, pointer wraps
        for (int r = 0; r < 6; r++) rand_round("R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule